// File: doc/BRIEF.md
# Interrupt Trap Unit

This unit decides, within one cycle of a single-cycle processor, whether the processor leaves its current path. The two reasons are an interrupt request that is allowed to enter, or a return-from-trap instruction. When it does, the unit asserts a redirect with the new fetch address. In the same cycle it drives the high-priority CSR write port with the values the trap CSRs must hold afterwards: the status word, the saved return address and the cause word. The unit holds no state. Every decision is a function of the current inputs.

The unit looks past the current status word to the value that word will have once the current instruction has executed. A CSR instruction that turns interrupts off in this cycle therefore blocks a request that arrives in the same cycle. A CSR instruction that turns them on lets the request in. The saved return address is the architectural next PC. A request that waits behind a return instruction stays pending and enters in the following cycle.

Top module: `irq_trap_unit`

## Requirements
- R1: When the interrupt-enable bit (status bit 3), as it stands after the current instruction, is 0, a pending request causes no redirect and no CSR write.
- R2: On entry, redirect is 1 and the redirect address equals the trap vector input. The status, return-address and cause write enables are all 1 in that same cycle.
- R3: On entry, the return-address write data is PC+4 (modulo 2^32) when no jump is taken, and the jump target when one is taken.
- R4: The cause write data has bit 31 set. Its code is 7 for request bit 0 (timer) and 11 for request bit 1 (external). When both bits are set, the external request wins.
- R5: On entry, the status write data has bit 7 (previous enable) set to 1, which is the enable value the request saw, and bit 3 cleared. All other bits are taken from the post-instruction status.
- R6: The instruction word 0x30200073 (return from trap) redirects to the saved-return-address input. It writes only the status word: bit 3 takes the old bit 7, bit 7 becomes 1, and all other bits are unchanged.
- R7: When a return-from-trap and a pending request fall in the same cycle, only the return is performed: no return-address or cause write.
- R8: A CSR instruction (opcode 0x73) aimed at CSR address 0x300 (bits 31:20) decides the enable the request sees. funct3 (bits 14:12) selects write (1), set (2) or clear (3) with the register operand. Values 5, 6 and 7 select the same operations with the 5-bit immediate in bits 19:15. Clearing bit 3 blocks a request in that cycle, and setting it admits one.
- R9: An instruction that is not a CSR access to address 0x300 leaves the enable as given by the status input, even if its other bits look like such an access.
- R10: With no request pending and no return-from-trap, redirect and all three write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_flags_i | input | 2 | Pending requests: bit 0 timer, bit 1 external |
| instr_i | input | 32 | Instruction executing this cycle |
| pc_i | input | 32 | Address of that instruction |
| jump_taken_i | input | 1 | The instruction redirects the PC |
| jump_addr_i | input | 32 | Target when jump_taken_i is 1 |
| csr_src_data_i | input | 32 | Register operand of a register-form CSR instruction |
| mstatus_i | input | 32 | Current machine status word |
| mtvec_i | input | 32 | Trap vector (handler address) |
| mepc_i | input | 32 | Saved return address |
| redirect_o | output | 1 | Override the next PC |
| redirect_addr_o | output | 32 | Next PC when redirect_o is 1 |
| mstatus_we_o | output | 1 | Write enable, status word |
| mstatus_wdata_o | output | 32 | New status word |
| mepc_we_o | output | 1 | Write enable, return address |
| mepc_wdata_o | output | 32 | New return address |
| mcause_we_o | output | 1 | Write enable, cause word |
| mcause_wdata_o | output | 32 | New cause word |

## Verification
The unit has no registers, so any internal fault appears at the ports in the same cycle as the input pattern that exposes it. A wrong post-instruction enable prediction shows up as a redirect beside a CSR clear of bit 3, or as a missing redirect beside a CSR set of bit 3. A wrong priority order shows up as cause code 7 while both request bits are set. An arbitration fault shows up as return-address or cause writes alongside a return instruction. The stimulus therefore pairs each CSR variant, each request pattern and the return instruction with pending requests, and checks every output in the cycle the pattern is applied.

// File: rtl/irq_pkg.sv
// Package: constants and helpers shared by the trap unit.
// Assumes a 32-bit machine-mode status layout with the enable at bit 3
// and the previous-enable at bit 7.
package irq_pkg;
    localparam int unsigned ST_IE_BIT   = 3;
    localparam int unsigned ST_PIE_BIT  = 7;
    localparam logic [11:0] CSR_STATUS  = 12'h300;
    localparam logic [6:0]  OPC_SYSTEM  = 7'h73;
    localparam logic [31:0] INSN_TRAPRET = 32'h3020_0073;
    localparam int unsigned CODE_W      = 5;

    // CSR operation kinds carried in funct3[1:0]
    typedef enum logic [1:0] {
        CSR_NONE  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_op_e;

    // Cause code of request line idx (timer, external, then software)
    function automatic logic [CODE_W-1:0] line_code(input int unsigned idx);
        case (idx)
            0:       line_code = 5'd7;
            1:       line_code = 5'd11;
            default: line_code = 5'd3;
        endcase
    endfunction
endpackage

// File: rtl/irq_prio_enc.sv
// Module: picks the highest-numbered pending request line and forms
// the cause word for it. Assumes higher line index = higher priority.
module irq_prio_enc
    import irq_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 2,
    parameter int unsigned XLEN    = 32
) (
    input  logic [NUM_IRQ-1:0] flags_i,
    output logic               any_o,
    output logic [XLEN-1:0]    cause_o
);
    localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

    logic [CODE_W-1:0] code;

    // Priority scan: the last set line in ascending order wins
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (flags_i[i]) code = line_code(i);
        end
    end

    assign any_o   = |flags_i;
    assign cause_o = {1'b1, {PAD_W{1'b0}}, code};
endmodule

// File: rtl/irq_status_predict.sv
// Module: computes the status word as it will stand after the current
// instruction, so the gate sees the enable the instruction leaves behind.
// Also flags the return-from-trap encoding. Assumes full-word match.
module irq_status_predict
    import irq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] status_i,
    output logic [XLEN-1:0] status_next_o,
    output logic            is_trapret_o
);
    logic [2:0]      funct3;
    logic            hits_status;
    csr_op_e         op;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] modified;

    assign funct3 = instr_i[14:12];
    assign op     = csr_op_e'(funct3[1:0]);

    // Decode: a CSR access aimed at the status register
    assign hits_status = (instr_i[6:0] == OPC_SYSTEM) && (op != CSR_NONE)
                       && (instr_i[31:20] == CSR_STATUS);

    // Operand: 5-bit immediate for funct3[2]=1, register otherwise
    assign operand = funct3[2] ? {{(XLEN-5){1'b0}}, instr_i[19:15]} : src_i;

    // Read-modify-write result of the CSR operation
    always_comb begin
        case (op)
            CSR_WRITE: modified = operand;
            CSR_SET:   modified = status_i | operand;
            CSR_CLEAR: modified = status_i & ~operand;
            default:   modified = status_i;
        endcase
    end

    assign status_next_o = hits_status ? modified : status_i;
    assign is_trapret_o  = (instr_i == INSN_TRAPRET);
endmodule

// File: rtl/irq_csr_compose.sv
// Module: forms the redirect and priority-port CSR writes for the two
// events. Assumes the caller makes take_irq_i and trapret_i exclusive.
module irq_csr_compose
    import irq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            take_irq_i,
    input  logic            trapret_i,
    input  logic [XLEN-1:0] status_now_i,
    input  logic [XLEN-1:0] status_next_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            jump_taken_i,
    input  logic [XLEN-1:0] jump_addr_i,
    input  logic [XLEN-1:0] cause_i,
    input  logic [XLEN-1:0] vector_i,
    input  logic [XLEN-1:0] ret_addr_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_addr_o,
    output logic            status_we_o,
    output logic [XLEN-1:0] status_wdata_o,
    output logic            epc_we_o,
    output logic [XLEN-1:0] epc_wdata_o,
    output logic            cause_we_o,
    output logic [XLEN-1:0] cause_wdata_o
);
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] entry_status;
    logic [XLEN-1:0] return_status;

    // Architectural next PC of the current instruction
    assign next_pc = jump_taken_i ? jump_addr_i : (pc_i + XLEN'(4));

    // Entry status: previous-enable gets the (set) enable, enable cleared
    always_comb begin
        entry_status             = status_next_i;
        entry_status[ST_PIE_BIT] = status_next_i[ST_IE_BIT];
        entry_status[ST_IE_BIT]  = 1'b0;
    end

    // Return status: enable restored from previous-enable, which is set
    always_comb begin
        return_status             = status_now_i;
        return_status[ST_IE_BIT]  = status_now_i[ST_PIE_BIT];
        return_status[ST_PIE_BIT] = 1'b1;
    end

    // Output selection per event
    always_comb begin
        redirect_o      = take_irq_i | trapret_i;
        redirect_addr_o = trapret_i ? ret_addr_i : vector_i;
        status_we_o     = take_irq_i | trapret_i;
        status_wdata_o  = trapret_i ? return_status : entry_status;
        epc_we_o        = take_irq_i;
        epc_wdata_o     = next_pc;
        cause_we_o      = take_irq_i;
        cause_wdata_o   = cause_i;
    end
endmodule

// File: rtl/irq_trap_unit.sv
// Module: top of the combinational trap unit. Gates pending requests
// with the post-instruction enable, arbitrates against return-from-trap
// (return wins, request waits a cycle) and drives the CSR port.
// Assumes the core applies the port writes at the next clock edge.
module irq_trap_unit
    import irq_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 2,
    parameter int unsigned XLEN    = 32
) (
    input  logic [NUM_IRQ-1:0] irq_flags_i,
    input  logic [31:0]        instr_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               jump_taken_i,
    input  logic [XLEN-1:0]    jump_addr_i,
    input  logic [XLEN-1:0]    csr_src_data_i,
    input  logic [XLEN-1:0]    mstatus_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic [XLEN-1:0]    mepc_i,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_addr_o,
    output logic               mstatus_we_o,
    output logic [XLEN-1:0]    mstatus_wdata_o,
    output logic               mepc_we_o,
    output logic [XLEN-1:0]    mepc_wdata_o,
    output logic               mcause_we_o,
    output logic [XLEN-1:0]    mcause_wdata_o
);
    logic            any_pending;
    logic [XLEN-1:0] cause_word;
    logic [XLEN-1:0] status_next;
    logic            is_trapret;
    logic            take_irq;

    irq_prio_enc #(.NUM_IRQ(NUM_IRQ), .XLEN(XLEN)) u_enc (
        .flags_i (irq_flags_i),
        .any_o   (any_pending),
        .cause_o (cause_word)
    );

    irq_status_predict #(.XLEN(XLEN)) u_pred (
        .instr_i       (instr_i),
        .src_i         (csr_src_data_i),
        .status_i      (mstatus_i),
        .status_next_o (status_next),
        .is_trapret_o  (is_trapret)
    );

    // Gate: enabled request, and no return-from-trap in this cycle
    assign take_irq = any_pending && status_next[ST_IE_BIT] && !is_trapret;

    irq_csr_compose #(.XLEN(XLEN)) u_comp (
        .take_irq_i      (take_irq),
        .trapret_i       (is_trapret),
        .status_now_i    (mstatus_i),
        .status_next_i   (status_next),
        .pc_i            (pc_i),
        .jump_taken_i    (jump_taken_i),
        .jump_addr_i     (jump_addr_i),
        .cause_i         (cause_word),
        .vector_i        (mtvec_i),
        .ret_addr_i      (mepc_i),
        .redirect_o      (redirect_o),
        .redirect_addr_o (redirect_addr_o),
        .status_we_o     (mstatus_we_o),
        .status_wdata_o  (mstatus_wdata_o),
        .epc_we_o        (mepc_we_o),
        .epc_wdata_o     (mepc_wdata_o),
        .cause_we_o      (mcause_we_o),
        .cause_wdata_o   (mcause_wdata_o)
    );
endmodule

// File: rtl/irq_trap_unit_chk.sv
// Module: port-level checker for the trap unit. The unit is purely
// combinational, so all checks are immediate and evaluated on settled
// values. Attached by the bind statement at the end of this file.
module irq_trap_unit_chk
    import irq_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 2,
    parameter int unsigned XLEN    = 32
) (
    input logic [NUM_IRQ-1:0] irq_flags_i,
    input logic [31:0]        instr_i,
    input logic [XLEN-1:0]    pc_i,
    input logic               jump_taken_i,
    input logic [XLEN-1:0]    mstatus_i,
    input logic [XLEN-1:0]    mtvec_i,
    input logic [XLEN-1:0]    mepc_i,
    input logic               redirect_o,
    input logic [XLEN-1:0]    redirect_addr_o,
    input logic               mstatus_we_o,
    input logic [XLEN-1:0]    mstatus_wdata_o,
    input logic               mepc_we_o,
    input logic [XLEN-1:0]    mepc_wdata_o,
    input logic               mcause_we_o,
    input logic [XLEN-1:0]    mcause_wdata_o
);
    // Port relations checked whenever any input settles
    always_comb begin
        if (!mstatus_i[ST_IE_BIT] && instr_i[6:0] != OPC_SYSTEM)
            a_r1_no_entry_when_off: assert (!mcause_we_o)
                else $error("R1: entry while enable clear");
        if (mcause_we_o)
            a_r2_entry_writes_all: assert (mepc_we_o && mstatus_we_o && redirect_o
                                           && redirect_addr_o == mtvec_i)
                else $error("R2: incomplete entry");
        if (mepc_we_o && !jump_taken_i)
            a_r3_sequential_return: assert (mepc_wdata_o == pc_i + XLEN'(4))
                else $error("R3: return address not PC+4");
        if (mcause_we_o)
            a_r4_cause_interrupt_bit: assert (mcause_wdata_o[XLEN-1])
                else $error("R4: cause top bit clear");
        if (mcause_we_o)
            a_r5_entry_status_bits: assert (!mstatus_wdata_o[ST_IE_BIT]
                                            && mstatus_wdata_o[ST_PIE_BIT])
                else $error("R5: entry status bits");
        if (instr_i == INSN_TRAPRET)
            a_r6_trapret_effect: assert (redirect_o && redirect_addr_o == mepc_i
                                         && mstatus_we_o && !mepc_we_o
                                         && mstatus_wdata_o[ST_IE_BIT] == mstatus_i[ST_PIE_BIT])
                else $error("R6: return effect");
        if (instr_i == INSN_TRAPRET && irq_flags_i != '0)
            a_r7_return_first: assert (!mcause_we_o)
                else $error("R7: entry beside return");
        if (irq_flags_i == '0 && instr_i != INSN_TRAPRET)
            a_r10_quiet_when_idle: assert (!redirect_o && !mstatus_we_o && !mepc_we_o)
                else $error("R10: activity while idle");
    end
endmodule

bind irq_trap_unit irq_trap_unit_chk #(.NUM_IRQ(NUM_IRQ), .XLEN(XLEN)) u_chk (
    .irq_flags_i     (irq_flags_i),
    .instr_i         (instr_i),
    .pc_i            (pc_i),
    .jump_taken_i    (jump_taken_i),
    .mstatus_i       (mstatus_i),
    .mtvec_i         (mtvec_i),
    .mepc_i          (mepc_i),
    .redirect_o      (redirect_o),
    .redirect_addr_o (redirect_addr_o),
    .mstatus_we_o    (mstatus_we_o),
    .mstatus_wdata_o (mstatus_wdata_o),
    .mepc_we_o       (mepc_we_o),
    .mepc_wdata_o    (mepc_wdata_o),
    .mcause_we_o     (mcause_we_o),
    .mcause_wdata_o  (mcause_wdata_o)
);

// File: tb/test_irq_trap_unit.sv
// Scoreboard bench: the driver applies a stimulus at a rising edge and
// queues the expected port values; the monitor compares at the falling edge.
module test_irq_trap_unit;
    localparam logic [31:0] VEC  = 32'h0000_2000;
    localparam logic [31:0] RET  = 32'h0000_3400;
    localparam logic [31:0] NOP  = 32'h0000_0013;
    localparam logic [31:0] TRET = 32'h3020_0073;

    typedef struct {
        string       tag;
        logic        redir;
        logic [31:0] raddr;
        logic        st_we;
        logic [31:0] st;
        logic        epc_we;
        logic [31:0] epc;
        logic        cause_we;
        logic [31:0] cause;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  flags = '0;
    logic [31:0] instr = NOP;
    logic [31:0] pc = '0;
    logic        jmp = 1'b0;
    logic [31:0] jaddr = '0;
    logic [31:0] src = '0;
    logic [31:0] mst = '0;
    logic        redir, st_we, epc_we, cause_we;
    logic [31:0] raddr, st_wd, epc_wd, cause_wd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    irq_trap_unit i_irq_trap_unit (
        .irq_flags_i (flags), .instr_i (instr), .pc_i (pc),
        .jump_taken_i (jmp), .jump_addr_i (jaddr), .csr_src_data_i (src),
        .mstatus_i (mst), .mtvec_i (VEC), .mepc_i (RET),
        .redirect_o (redir), .redirect_addr_o (raddr),
        .mstatus_we_o (st_we), .mstatus_wdata_o (st_wd),
        .mepc_we_o (epc_we), .mepc_wdata_o (epc_wd),
        .mcause_we_o (cause_we), .mcause_wdata_o (cause_wd)
    );

    function automatic exp_t quiet(string t);
        exp_t e;
        e = '{t, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0};
        return e;
    endfunction

    function automatic exp_t entry(string t, logic [31:0] s, logic [31:0] r, logic [31:0] c);
        exp_t e;
        e = '{t, 1'b1, VEC, 1'b1, s, 1'b1, r, 1'b1, c};
        return e;
    endfunction

    function automatic exp_t tret(string t, logic [31:0] s);
        exp_t e;
        e = '{t, 1'b1, RET, 1'b1, s, 1'b0, '0, 1'b0, '0};
        return e;
    endfunction

    // Driver: apply one input pattern and queue its expectation
    task automatic drive(input logic [1:0] f, input logic [31:0] i, input logic [31:0] p,
                         input logic j, input logic [31:0] ja, input logic [31:0] s,
                         input logic [31:0] m, input exp_t e);
        @(posedge clk);
        flags = f; instr = i; pc = p; jmp = j; jaddr = ja; src = s; mst = m;
        q.push_back(e);
    endtask

    // Monitor: compare settled outputs against the queued expectation
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = (redir !== e.redir) || (st_we !== e.st_we) || (epc_we !== e.epc_we)
               || (cause_we !== e.cause_we)
               || (e.redir && raddr !== e.raddr) || (e.st_we && st_wd !== e.st)
               || (e.epc_we && epc_wd !== e.epc) || (e.cause_we && cause_wd !== e.cause);
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s: got redir=%b addr=%h st=%b/%h epc=%b/%h cause=%b/%h exp redir=%b addr=%h st=%b/%h epc=%b/%h cause=%b/%h",
                         e.tag, redir, raddr, st_we, st_wd, epc_we, epc_wd, cause_we, cause_wd,
                         e.redir, e.raddr, e.st_we, e.st, e.epc_we, e.epc, e.cause_we, e.cause);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10 reset/idle state
        drive(2'b00, NOP, 32'h1900, 0, 0, 0, 32'h1888, quiet("R10 idle"));
        // R1 enable clear blocks a request
        drive(2'b01, NOP, 32'h1900, 0, 0, 0, 32'h1880, quiet("R1 enable clear"));
        // R2 R3 R4 R5 timer entry, sequential
        drive(2'b01, NOP, 32'h1900, 0, 0, 0, 32'h1888,
              entry("R2/R3/R4/R5 timer entry", 32'h1880, 32'h1904, 32'h8000_0007));
        // R3 R4 external entry, jump taken
        drive(2'b10, NOP, 32'h1900, 1, 32'h1990, 0, 32'h1888,
              entry("R3/R4 jump target external", 32'h1880, 32'h1990, 32'h8000_000B));
        // R4 both lines: external wins
        drive(2'b11, NOP, 32'h1A00, 0, 0, 0, 32'h1888,
              entry("R4 priority", 32'h1880, 32'h1A04, 32'h8000_000B));
        // R5 unrelated bits kept
        drive(2'b01, NOP, 32'h1900, 0, 0, 0, 32'h188A,
              entry("R5 other bits", 32'h1882, 32'h1904, 32'h8000_0007));
        // R3 wrap of PC+4
        drive(2'b01, NOP, 32'hFFFF_FFFC, 0, 0, 0, 32'h1888,
              entry("R3 wrap", 32'h1880, 32'h0, 32'h8000_0007));
        // R6 return from trap
        drive(2'b00, TRET, 32'h1904, 0, 0, 0, 32'h1880, tret("R6 return", 32'h1888));
        // R6 return with previous-enable clear
        drive(2'b00, TRET, 32'h1904, 0, 0, 0, 32'h1800, tret("R6 return pie0", 32'h1880));
        // R7 return beside a pending request
        drive(2'b01, TRET, 32'h1904, 0, 0, 0, 32'h1880, tret("R7 return first", 32'h1888));
        // R7 the request then enters a cycle later
        drive(2'b01, NOP, 32'h3400, 0, 0, 0, 32'h1888,
              entry("R7 deferred entry", 32'h1880, 32'h3404, 32'h8000_0007));
        // R8 clear by register operand
        drive(2'b01, 32'h3002B073, 32'h1900, 0, 0, 32'h8, 32'h1888, quiet("R8 clear reg"));
        // R8 clear by immediate 8
        drive(2'b10, 32'h30047073, 32'h1900, 0, 0, 0, 32'h1888, quiet("R8 clear imm"));
        // R8 write of zero
        drive(2'b01, 32'h30029073, 32'h1900, 0, 0, 32'h0, 32'h1888, quiet("R8 write zero"));
        // R8 write keeping the enable
        drive(2'b01, 32'h30029073, 32'h1900, 0, 0, 32'h1888, 32'h1880,
              entry("R8 write keep", 32'h1880, 32'h1904, 32'h8000_0007));
        // R8 set by immediate 8 admits the request
        drive(2'b01, 32'h30046073, 32'h1900, 0, 0, 0, 32'h1880,
              entry("R8 set imm", 32'h1880, 32'h1904, 32'h8000_0007));
        // R8 write-immediate zero blocks
        drive(2'b01, 32'h30005073, 32'h1900, 0, 0, 0, 32'h1888, quiet("R8 write imm zero"));
        // R8 set with zero operand leaves enable on
        drive(2'b01, 32'h3002A073, 32'h1900, 0, 0, 32'h0, 32'h1888,
              entry("R8 set zero", 32'h1880, 32'h1904, 32'h8000_0007));
        // R9 clear aimed at another CSR
        drive(2'b01, 32'h3042B073, 32'h1900, 0, 0, 32'h8, 32'h1888,
              entry("R9 other csr", 32'h1880, 32'h1904, 32'h8000_0007));
        // R9 non-system opcode with look-alike bits
        drive(2'b10, 32'h3002B033, 32'h1900, 0, 0, 32'h8, 32'h1888,
              entry("R9 other opcode", 32'h1880, 32'h1904, 32'h8000_000B));
        // R1 non-CSR instruction cannot enable
        drive(2'b10, 32'h3002A033, 32'h1900, 0, 0, 32'h8, 32'h1880, quiet("R1 R9 no enable"));
        // R10 idle again
        drive(2'b00, NOP, 32'h1900, 0, 0, 0, 32'h1880, quiet("R10 idle end"));
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule